// File: doc/BRIEF.md
# Posted-Write Bridge with Read-Hazard Guard

This bridge sits on the slave side of a single-ID, single-beat request fabric and forwards every access to a narrow downstream bus that uses a request/acknowledge handshake. A write flagged as bufferable is placed in a small posted-write queue and answered at once, before its data reaches the downstream target. A write without that flag is answered only after the downstream side acknowledges it.

Because early answers hide writes that are still queued, the bridge guards every read. A static mode input selects the guard. In address-compare mode (`hz_mode` = 0), the read waits only while its address matches a queued write. It may pass writes that do not match. In drain mode (`hz_mode` = 1), the whole queue empties before any read is issued. Downstream accesses go out one at a time. Queued writes keep their acceptance order.

A central state machine drives the downstream port. Its states are `DS_IDLE`, `DS_WRQ` (issuing the queue head), `DS_WRNB` (issuing the held non-bufferable write) and `DS_RD` (issuing the held read). From `DS_IDLE` it goes to `DS_RD` when a read is held and not blocked. Otherwise it goes to `DS_WRQ` when the queue has entries. Otherwise it goes to `DS_WRNB` when a non-bufferable write is held. Each busy state returns to `DS_IDLE` on the acknowledge cycle. `QDEPTH` must be a power of two.

Top module: `wpost_bridge`

## Requirements
- R1: During and after reset the queue is empty and `wr_ready` and `rd_ready` are 1, while `bresp_valid`, `rresp_valid` and `dn_req` are 0.
- R2: A bufferable write (`wr_buf` = 1) raises `bresp_valid` in the cycle after its acceptance. At that point `dn_req` is still 0.
- R3: Queued writes appear downstream with `dn_we` = 1, carrying their address and data, in the order they were accepted.
- R4: The queue holds `QDEPTH` (4) writes. When it is full, `wr_ready` is 0 until an entry is issued and acknowledged.
- R5: A non-bufferable write (`wr_buf` = 0) is issued only once the queue is empty. Its `bresp_valid` rises only in the cycle after its downstream acknowledge.
- R6: With `hz_mode` = 0, a read that matches a queued address is held until every queued write up to and including the youngest match has been acknowledged. It then returns the new data and may go ahead of any later non-matching writes.
- R7: With `hz_mode` = 0, a read that matches no queued write is issued downstream ahead of the writes still waiting in the queue.
- R8: With `hz_mode` = 1, a read is issued only after the queue has fully drained, whatever its address.
- R9: Only one downstream access is outstanding. `dn_req`, `dn_we`, `dn_addr` and `dn_wdata` stay stable until the `dn_ack` cycle.
- R10: Read data is captured in the `dn_ack` cycle and returned with `rresp_valid`. Both stay stable until `rresp_ready` is 1.
- R11: No new write is accepted (`wr_ready` = 0) while a write response is waiting for `bresp_ready`, while a non-bufferable write is outstanding, or while a read is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hz_mode | input | 1 | Read guard: 0 address compare, 1 full drain |
| wr_valid | input | 1 | Write request valid (address and data together) |
| wr_ready | output | 1 | Write request accepted when high with `wr_valid` |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_buf | input | 1 | 1 marks the write as bufferable |
| bresp_valid | output | 1 | Write response valid |
| bresp_ready | input | 1 | Write response taken |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | ADDR_W | Read address |
| rresp_valid | output | 1 | Read data valid |
| rresp_ready | input | 1 | Read data taken |
| rresp_data | output | DATA_W | Read data |
| dn_req | output | 1 | Downstream request, held until acknowledge |
| dn_we | output | 1 | Downstream direction, 1 for write |
| dn_addr | output | ADDR_W | Downstream address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge pulse |
| dn_rdata | input | DATA_W | Downstream read data, valid in the acknowledge cycle |

## Verification
An accepted bufferable write shows `bresp_valid` one edge after acceptance. The new queue entry raises `dn_req` one edge after that. A held read or write leaves `DS_IDLE` one edge after it is held, and completes on the edge where `dn_ack` is seen. Read data appears on `rresp_valid` at that same acknowledge edge. The bench drives and samples on the falling edge, so every check reads values half a cycle after the rising edge that produced them. Ordering checks use a log of the acknowledged downstream accesses. The bench model can hold off acknowledges, which keeps writes queued while a read arrives, and then compares the position of the read in that log.

// File: rtl/wpost_pkg.sv
package wpost_pkg;
    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_WRQ  = 2'd1,
        DS_WRNB = 2'd2,
        DS_RD   = 2'd3
    } ds_state_t;
endpackage

// File: rtl/wpost_queue.sv
module wpost_queue #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [AW-1:0]       push_addr,
    input  logic [DW-1:0]       push_data,
    input  logic                pop,
    output logic [AW-1:0]       head_addr,
    output logic [DW-1:0]       head_data,
    output logic                empty,
    output logic                full,
    output logic [DEPTH-1:0]    slot_vld,
    output logic [DEPTH*AW-1:0] slot_addr
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [AW-1:0] a_mem [DEPTH];
    logic [DW-1:0] d_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            slot_vld <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (push && wr_ptr == PW'(i))
                    slot_vld[i] <= 1'b1;
                else if (pop && rd_ptr == PW'(i))
                    slot_vld[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            a_mem[wr_ptr] <= push_addr;
            d_mem[wr_ptr] <= push_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_addr[g*AW +: AW] = a_mem[g];
    end

    assign head_addr = a_mem[rd_ptr];
    assign head_data = d_mem[rd_ptr];
    assign empty     = ~|slot_vld;
    assign full      = &slot_vld;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wpost_hazard.sv
module wpost_hazard #(
    parameter int AW    = 8,
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0]    slot_vld,
    input  logic [DEPTH*AW-1:0] slot_addr,
    input  logic [AW-1:0]       probe_addr,
    input  logic                drain_mode,
    output logic                hit_any,
    output logic                hold
);
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = slot_vld[g] && (slot_addr[g*AW +: AW] == probe_addr);
    end

    always_comb begin
        hit_any = |hit;
        hold    = drain_mode ? (|slot_vld) : hit_any;
    end
endmodule

// File: rtl/wpost_bridge.sv
module wpost_bridge
    import wpost_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hz_mode,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_buf,
    output logic              bresp_valid,
    input  logic              bresp_ready,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rresp_valid,
    input  logic              rresp_ready,
    output logic [DATA_W-1:0] rresp_data,
    output logic              dn_req,
    output logic              dn_we,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ack,
    input  logic [DATA_W-1:0] dn_rdata
);
    ds_state_t state_q, state_d;

    logic              nb_held_q, rd_held_q;
    logic [ADDR_W-1:0] nb_addr_q, rd_addr_q;
    logic [DATA_W-1:0] nb_data_q;

    logic                     q_push, q_pop, q_empty, q_full;
    logic [ADDR_W-1:0]        q_head_addr;
    logic [DATA_W-1:0]        q_head_data;
    logic [QDEPTH-1:0]        q_vld;
    logic [QDEPTH*ADDR_W-1:0] q_addrs;
    logic                     rd_hit_any, rd_hold;

    logic wr_fire, rd_fire, done_wrq, done_wrnb, done_rd;

    assign wr_ready  = !bresp_valid && !nb_held_q && !rd_held_q && !q_full;
    assign rd_ready  = !rd_held_q && !rresp_valid;
    assign wr_fire   = wr_valid && wr_ready;
    assign rd_fire   = rd_valid && rd_ready;
    assign q_push    = wr_fire && wr_buf;
    assign done_wrq  = (state_q == DS_WRQ)  && dn_ack;
    assign done_wrnb = (state_q == DS_WRNB) && dn_ack;
    assign done_rd   = (state_q == DS_RD)   && dn_ack;
    assign q_pop     = done_wrq;

    wpost_queue #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(QDEPTH)) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (q_pop),
        .head_addr (q_head_addr),
        .head_data (q_head_data),
        .empty     (q_empty),
        .full      (q_full),
        .slot_vld  (q_vld),
        .slot_addr (q_addrs)
    );

    wpost_hazard #(.AW(ADDR_W), .DEPTH(QDEPTH)) hazard_i (
        .slot_vld   (q_vld),
        .slot_addr  (q_addrs),
        .probe_addr (rd_addr_q),
        .drain_mode (hz_mode),
        .hit_any    (rd_hit_any),
        .hold       (rd_hold)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE: begin
                if (rd_held_q && !rd_hold) state_d = DS_RD;
                else if (!q_empty)         state_d = DS_WRQ;
                else if (nb_held_q)        state_d = DS_WRNB;
            end
            DS_WRQ, DS_WRNB, DS_RD: begin
                if (dn_ack) state_d = DS_IDLE;
            end
            default: state_d = DS_IDLE;
        endcase
    end

    // state register and held requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= DS_IDLE;
            bresp_valid <= 1'b0;
            nb_held_q   <= 1'b0;
            nb_addr_q   <= '0;
            nb_data_q   <= '0;
            rd_held_q   <= 1'b0;
            rd_addr_q   <= '0;
            rresp_valid <= 1'b0;
            rresp_data  <= '0;
        end else begin
            state_q <= state_d;
            if (q_push || done_wrnb)               bresp_valid <= 1'b1;
            else if (bresp_valid && bresp_ready)   bresp_valid <= 1'b0;
            if (wr_fire && !wr_buf) begin
                nb_held_q <= 1'b1;
                nb_addr_q <= wr_addr;
                nb_data_q <= wr_data;
            end else if (done_wrnb) begin
                nb_held_q <= 1'b0;
            end
            if (rd_fire) begin
                rd_held_q <= 1'b1;
                rd_addr_q <= rd_addr;
            end else if (done_rd) begin
                rd_held_q <= 1'b0;
            end
            if (done_rd) begin
                rresp_valid <= 1'b1;
                rresp_data  <= dn_rdata;
            end else if (rresp_valid && rresp_ready) begin
                rresp_valid <= 1'b0;
            end
        end
    end

    // downstream outputs
    always_comb begin
        dn_req   = 1'b0;
        dn_we    = 1'b0;
        dn_addr  = '0;
        dn_wdata = '0;
        unique case (state_q)
            DS_IDLE: ;
            DS_WRQ: begin
                dn_req   = 1'b1;
                dn_we    = 1'b1;
                dn_addr  = q_head_addr;
                dn_wdata = q_head_data;
            end
            DS_WRNB: begin
                dn_req   = 1'b1;
                dn_we    = 1'b1;
                dn_addr  = nb_addr_q;
                dn_wdata = nb_data_q;
            end
            DS_RD: begin
                dn_req  = 1'b1;
                dn_addr = rd_addr_q;
            end
            default: ;
        endcase
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req && $stable(dn_we) && $stable(dn_addr) && $stable(dn_wdata));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rresp_valid && !rresp_ready |=> rresp_valid && $stable(rresp_data));

    // R6
    rd_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req) && !dn_we |-> !rd_hit_any);

    // R8
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req) && !dn_we && $past(hz_mode) |-> q_empty);

    // R5
    nb_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_WRNB) |-> q_empty);

    // R11
    no_wr_during_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_held_q |-> !q_push);
endmodule

// File: tb/wpost_bridge_tb_top.sv
module wpost_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hz_mode = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_buf = 1'b0;
    logic          bresp_valid;
    logic          bresp_ready = 1'b1;
    logic          rd_valid = 1'b0;
    logic          rd_ready;
    logic [AW-1:0] rd_addr = '0;
    logic          rresp_valid;
    logic          rresp_ready = 1'b1;
    logic [DW-1:0] rresp_data;
    logic          dn_req, dn_we;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata;
    logic          dn_ack = 1'b0;
    logic [DW-1:0] dn_rdata;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpost_bridge #(.ADDR_W(AW), .DATA_W(DW), .QDEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .hz_mode(hz_mode),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_buf(wr_buf),
        .bresp_valid(bresp_valid), .bresp_ready(bresp_ready),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rresp_valid(rresp_valid), .rresp_ready(rresp_ready), .rresp_data(rresp_data),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    // downstream target model
    logic [DW-1:0] mem [256];
    bit  stall = 0;
    int  lat = 2;
    int  wcnt = 0;
    logic          log_we   [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int  log_n = 0;

    initial for (int i = 0; i < 256; i++) mem[i] = 16'hA500 | DW'(i);

    assign dn_rdata = mem[dn_addr];

    always @(negedge clk) begin
        if (dn_ack) begin
            dn_ack = 1'b0;
            wcnt = 0;
        end else if (dn_req && !stall) begin
            wcnt++;
            if (wcnt >= lat) dn_ack = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst_n && dn_req && dn_ack) begin
            log_we[log_n]   <= dn_we;
            log_addr[log_n] <= dn_addr;
            log_data[log_n] <= dn_wdata;
            if (dn_we) mem[dn_addr] <= dn_wdata;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    task automatic wr_send(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic b);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_buf = b;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd_start(input logic [AW-1:0] a);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        while (!rd_ready) @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic rd_wait(output logic [DW-1:0] d);
        while (!rresp_valid) @(negedge clk);
        d = rresp_data;
    endtask

    task automatic wait_log(input int n);
        while (log_n < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 wr_ready", 32'(wr_ready), 1);
        chk("R1 rd_ready", 32'(rd_ready), 1);
        chk("R1 bresp_valid", 32'(bresp_valid), 0);
        chk("R1 rresp_valid", 32'(rresp_valid), 0);
        chk("R1 dn_req", 32'(dn_req), 0);
    endtask

    task automatic t_posted_order();
        int base = log_n;
        stall = 0;
        wr_send(8'h11, 16'h1111, 1'b1);
        chk("R2 early bresp", 32'(bresp_valid), 1);
        chk("R2 not yet downstream", 32'(dn_req), 0);
        wr_send(8'h12, 16'h1212, 1'b1);
        wr_send(8'h13, 16'h1313, 1'b1);
        wait_log(base + 3);
        for (int i = 0; i < 3; i++) begin
            chk("R3 we", 32'(log_we[base+i]), 1);
            chk("R3 addr order", 32'(log_addr[base+i]), 32'(8'h11 + i));
        end
        chk("R3 data", 32'(log_data[base+2]), 32'h1313);
    endtask

    task automatic t_full();
        int base = log_n;
        logic [AW-1:0] a0;
        stall = 1;
        for (int i = 0; i < 4; i++) wr_send(AW'(8'h21 + i), DW'(16'h2100 + i), 1'b1);
        @(negedge clk);
        chk("R4 full blocks write", 32'(wr_ready), 0);
        a0 = dn_addr;
        repeat (3) @(negedge clk);
        chk("R9 req held", 32'(dn_req), 1);
        chk("R9 addr stable", 32'(dn_addr), 32'(a0));
        chk("R4 still full", 32'(wr_ready), 0);
        stall = 0;
        wait_log(base + 4);
        for (int i = 0; i < 4; i++)
            chk("R3 drain order", 32'(log_addr[base+i]), 32'(8'h21 + i));
        chk("R4 ready after drain", 32'(wr_ready), 1);
    endtask

    task automatic t_nonbuf();
        int base = log_n;
        int guard = 0;
        stall = 1;
        wr_send(8'h31, 16'h3131, 1'b1);
        wr_send(8'h32, 16'h3232, 1'b1);
        wr_send(8'h33, 16'h3333, 1'b0);
        chk("R5 no early bresp", 32'(bresp_valid), 0);
        chk("R11 nb blocks write", 32'(wr_ready), 0);
        repeat (4) @(negedge clk);
        chk("R5 still no bresp", 32'(bresp_valid), 0);
        stall = 0;
        while (!bresp_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk("R5 bresp after ack", 32'(bresp_valid), 1);
        chk("R5 all three done", 32'(log_n - base), 3);
        chk("R5 nb issued last", 32'(log_addr[base+2]), 32'h33);
        chk("R5 nb data", 32'(log_data[base+2]), 32'h3333);
    endtask

    task automatic t_m0_hit();
        int base = log_n;
        logic [DW-1:0] d;
        hz_mode = 0;
        stall = 1;
        wr_send(8'h41, 16'h4141, 1'b1);
        wr_send(8'h42, 16'h4242, 1'b1);
        wr_send(8'h43, 16'h4343, 1'b1);
        rd_start(8'h42);
        stall = 0;
        rd_wait(d);
        chk("R6 read sees new data", 32'(d), 32'h4242);
        wait_log(base + 4);
        chk("R6 read after match", 32'(log_we[base+2]), 0);
        chk("R6 read addr", 32'(log_addr[base+2]), 32'h42);
        chk("R6 later write after read", 32'(log_addr[base+3]), 32'h43);
    endtask

    task automatic t_m0_miss();
        int base = log_n;
        logic [DW-1:0] d;
        hz_mode = 0;
        stall = 1;
        wr_send(8'h51, 16'h5151, 1'b1);
        wr_send(8'h52, 16'h5252, 1'b1);
        wr_send(8'h53, 16'h5353, 1'b1);
        rd_start(8'h5A);
        stall = 0;
        rd_wait(d);
        chk("R7 read data", 32'(d), 32'hA55A);
        wait_log(base + 4);
        chk("R7 read overtakes", 32'(log_we[base+1]), 0);
        chk("R7 read addr", 32'(log_addr[base+1]), 32'h5A);
    endtask

    task automatic t_m1();
        int base = log_n;
        logic [DW-1:0] d;
        hz_mode = 1;
        stall = 1;
        wr_send(8'h61, 16'h6161, 1'b1);
        wr_send(8'h62, 16'h6262, 1'b1);
        wr_send(8'h63, 16'h6363, 1'b1);
        rd_start(8'h6A);
        stall = 0;
        rd_wait(d);
        chk("R8 read data", 32'(d), 32'hA56A);
        wait_log(base + 4);
        chk("R8 read last", 32'(log_we[base+3]), 0);
        chk("R8 write before read", 32'(log_addr[base+2]), 32'h63);
        hz_mode = 0;
    endtask

    task automatic t_rhold();
        logic [DW-1:0] d;
        stall = 0;
        rresp_ready = 0;
        rd_start(8'h71);
        rd_wait(d);
        chk("R10 data", 32'(d), 32'hA571);
        repeat (3) @(negedge clk);
        chk("R10 valid held", 32'(rresp_valid), 1);
        chk("R10 data held", 32'(rresp_data), 32'hA571);
        rresp_ready = 1;
        @(negedge clk);
        chk("R10 released", 32'(rresp_valid), 0);
    endtask

    task automatic t_bblock();
        bresp_ready = 0;
        wr_send(8'h81, 16'h8181, 1'b1);
        repeat (3) @(negedge clk);
        chk("R11 bresp pending", 32'(bresp_valid), 1);
        chk("R11 write blocked", 32'(wr_ready), 0);
        bresp_ready = 1;
        @(negedge clk);
        chk("R11 bresp taken", 32'(bresp_valid), 0);
        chk("R11 write open", 32'(wr_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 dn_req in reset", 32'(dn_req), 0);
        rst_n = 1'b1;
        t_reset();
        t_posted_order();
        t_full();
        t_nonbuf();
        t_m0_hit();
        t_m0_miss();
        t_m1();
        t_rhold();
        t_bblock();
        repeat (5) @(negedge clk);
        summary();
    end
endmodule